// File: doc/BRIEF.md
# Dual-Modulus Divider Controller

This block turns a fast input clock into one pulse every `MOD_V*N1 + N2` input clocks. A small prescaler counts each period as either `MOD_V` or `MOD_V+1` clocks, depending on its mode line. Two programmable down counters count prescaler periods. The cycle counter starts at N1. The mode counter starts at N2 and holds the prescaler in its long mode while its count is non-zero. With this arrangement the division ratio moves in steps of one input clock, not in steps of `MOD_V`.

In a synthesizer loop, the pulse output feeds a phase comparator and the mode output steers an external two-ratio prescaler. Here the prescaler is modelled inside the block as a counter. The presets are sampled at reset and again at each cycle boundary. A change to a preset in the middle of a cycle therefore takes effect only at the next boundary. The presets must satisfy N1 ≥ 1 and N1 ≥ N2. With `MOD_V=10`, every ratio from 90 upward can be reached using N1 ≥ 9 and N2 in 0..9.

Top module: `dmd_divider`

## Requirements
- R1: `cycle_pulse` is high for exactly one clock, and consecutive pulses are exactly `MOD_V*N1 + N2` clocks apart. For example, N1=1 and N2=1 give `MOD_V+1`, and N1=9 and N2=0 give `9*MOD_V`.
- R2: Within each cycle, `mode_hi` (1 = long period of `MOD_V+1`, 0 = short period of `MOD_V`) is high for the first N2 prescaler periods. That is `N2*(MOD_V+1)` clocks. It is low for the remaining N1−N2 periods.
- R3: `mode_hi` changes only where one prescaler period ends and the next begins. It is never changed part-way through a period.
- R4: The mode counter does not decrement below zero. Once it reaches zero, `mode_hi` stays low until the next reload.
- R5: When the cycle counter is exhausted, both counters reload from the presets at the same clock edge. That edge raises `cycle_pulse`, and `mode_hi` can rise only together with `cycle_pulse`.
- R6: With N2=0, every prescaler period lasts `MOD_V` clocks and `mode_hi` stays low for the whole cycle.
- R7: A synchronous active-high `rst` holds `cycle_pulse` low and sets `mode_hi` to (N2 ≠ 0). When `rst` is released, a new cycle starts at prescaler count zero, and the first pulse comes `MOD_V*N1 + N2` clocks after the last reset edge. This also holds when reset is applied in the middle of a cycle.
- R8: A preset change during a cycle does not alter that cycle's length or mode pattern. It takes effect only from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the presets |
| n1_preset | input | CNT_W | Cycle counter preset (prescaler periods per cycle) |
| n2_preset | input | CNT_W | Mode counter preset (long periods per cycle) |
| cycle_pulse | output | 1 | One-clock pulse at the end of each full division cycle |
| mode_hi | output | 1 | Prescaler ratio select: 1 selects MOD_V+1, 0 selects MOD_V |

## Verification
The bench targets the edges of the preset range, where an off-by-one in the reload point is easiest to see. For N1=N2, the mode counter reaches zero on the same edge as the reload; a design that favoured the decrement over the load would then run the second cycle short. For N1=1, a single period makes up the whole cycle; a design that reloaded on zero instead of on the final period would add a whole extra period. Mode-high time is counted in two consecutive cycles. A mode counter that wrapped below zero would show extra long periods, and a counter that was not reloaded would show none in the second cycle. Mid-cycle preset changes and mid-cycle resets are applied to confirm that presets are sampled only at boundaries and that reset restarts the prescaler from zero.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic {
    DIV_BASE  = 1'b0,
    DIV_PLUS1 = 1'b1
  } div_mode_e;
endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int MOD_V = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  dmd_pkg::div_mode_e  mode_i,
  output logic                tc_o
);
  localparam int PW = $clog2(MOD_V + 1);
  localparam logic [PW-1:0] LAST_BASE = PW'(MOD_V - 1);
  localparam logic [PW-1:0] LAST_PLUS = PW'(MOD_V);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last_idx;

  assign last_idx = (mode_i == dmd_pkg::DIV_PLUS1) ? LAST_PLUS : LAST_BASE;
  assign tc_o     = (pcnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst || tc_o) pcnt <= '0;
    else             pcnt <= pcnt + PW'(1);
  end

  // The period counter never runs past the long-period length.
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    pcnt <= LAST_PLUS);

  // The mode is only allowed to change at the start of a period.
  assert_mode_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (pcnt != '0) |-> $stable(mode_i));
endmodule

// File: rtl/dmd_downcnt.sv
module dmd_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             load_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o
);
  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      cnt_o <= preset_i;
      nz_o  <= (preset_i != '0);
    end else if (dec_i && nz_o) begin
      cnt_o <= cnt_o - CNT_W'(1);
      nz_o  <= (cnt_o != CNT_W'(1));
    end
  end

  // Once at zero, the counter stays there until a load.
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!nz_o && !load_i) |=> (!nz_o && cnt_o == '0));

  assert_status_tracks_count_R4: assert property (@(posedge clk) disable iff (rst)
    nz_o == (cnt_o != '0));
endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
  parameter int MOD_V = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] n1_preset,
  input  logic [CNT_W-1:0] n2_preset,
  output logic             cycle_pulse,
  output logic             mode_hi
);
  logic             tc;
  logic             reload;
  logic [CNT_W-1:0] cyc_cnt;
  logic             cyc_nz;
  logic [CNT_W-1:0] mode_cnt;
  logic             mode_nz;
  dmd_pkg::div_mode_e mode_sel;

  assign mode_sel = dmd_pkg::div_mode_e'(mode_nz);
  assign reload   = tc && (cyc_cnt <= CNT_W'(1));
  assign mode_hi  = mode_nz;

  dmd_prescaler #(.MOD_V(MOD_V)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_sel),
    .tc_o   (tc)
  );

  dmd_downcnt #(.CNT_W(CNT_W)) u_cyc_cnt (
    .clk      (clk),
    .rst      (rst),
    .preset_i (n1_preset),
    .load_i   (reload),
    .dec_i    (tc),
    .cnt_o    (cyc_cnt),
    .nz_o     (cyc_nz)
  );

  dmd_downcnt #(.CNT_W(CNT_W)) u_mode_cnt (
    .clk      (clk),
    .rst      (rst),
    .preset_i (n2_preset),
    .load_i   (reload),
    .dec_i    (tc),
    .cnt_o    (mode_cnt),
    .nz_o     (mode_nz)
  );

  always_ff @(posedge clk) begin
    if (rst) cycle_pulse <= 1'b0;
    else     cycle_pulse <= reload;
  end

  assert_pulse_one_clock_R1: assert property (@(posedge clk) disable iff (rst)
    cycle_pulse |=> !cycle_pulse);

  assert_mode_rises_at_reload_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_hi) |-> cycle_pulse);

  // The cycle counter is reloaded before it ever reaches zero.
  assert_cycle_never_empty_R5: assert property (@(posedge clk) disable iff (rst)
    cycle_pulse |-> (cyc_nz || n1_preset == '0 || $past(n1_preset) == '0));
endmodule

// File: tb/dmd_divider_bench.sv
module dmd_divider_bench;
  localparam int V  = 10;
  localparam int CW = 8;
  localparam int NCASE = 7;
  // each row: N1, N2, expected ratio V*N1+N2
  localparam int VEC [0:NCASE-1][0:2] = '{
    '{9, 0, 90}, '{9, 9, 99}, '{10, 3, 103}, '{12, 5, 125},
    '{20, 20, 220}, '{1, 0, 10}, '{1, 1, 11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] n1_r = CW'(9);
  logic [CW-1:0] n2_r = '0;
  logic cycle_pulse, mode_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dmd_divider #(.MOD_V(V), .CNT_W(CW)) u_dmd_divider (
    .clk(clk), .rst(rst), .n1_preset(n1_r), .n2_preset(n2_r),
    .cycle_pulse(cycle_pulse), .mode_hi(mode_hi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply reset with the given presets and check the reset state (R7).
  task automatic do_reset(input int n1, input int n2);
    n1_r = CW'(n1);
    n2_r = CW'(n2);
    rst  = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(cycle_pulse == 1'b0, "R7 pulse low in reset", cycle_pulse, 0);
    check(mode_hi == (n2 != 0), "R7 mode in reset", mode_hi, n2 != 0);
  endtask

  // Observe two full cycles after release.
  task automatic run_case(input int n1, input int n2, input int exp);
    int first = 0, second = 0, npulse = 0, mh1 = 0, mh2 = 0;
    do_reset(n1, n2);
    mh1 = mode_hi ? 1 : 0;
    rst = 1'b0;
    for (int i = 1; i <= 2 * exp + 1; i++) begin
      @(negedge clk);
      if (cycle_pulse) begin
        npulse++;
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
      if (mode_hi && i < exp) mh1++;
      if (mode_hi && i >= exp && i < 2 * exp) mh2++;
    end
    check(first == exp, "R1 first pulse position", first, exp);
    check(second == 2 * exp, "R1 R5 second pulse position", second, 2 * exp);
    check(npulse == 2, "R1 pulse count one clock wide", npulse, 2);
    if (n2 == 0)
      check(mh1 == 0, "R6 mode stays low with N2=0", mh1, 0);
    else
      check(mh1 == n2 * (V + 1), "R2 R4 mode-high clocks cycle 1", mh1, n2 * (V + 1));
    check(mh2 == n2 * (V + 1), "R2 R5 mode-high clocks cycle 2", mh2, n2 * (V + 1));
  endtask

  initial begin
    int first, second, mh;
    for (int k = 0; k < NCASE; k++)
      run_case(VEC[k][0], VEC[k][1], VEC[k][2]);

    // R8: presets changed mid-cycle only take effect at the next reload
    do_reset(9, 0);
    rst = 1'b0;
    first = 0; second = 0; mh = 0;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (i == 40) begin n1_r = CW'(10); n2_r = CW'(3); end
      if (cycle_pulse) begin
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
      if (mode_hi && i < 90) mh++;
    end
    check(first == 90, "R8 old ratio kept", first, 90);
    check(mh == 0, "R8 old mode pattern kept", mh, 0);
    check(second == 193, "R8 new ratio next cycle", second, 193);

    // R7: reset in the middle of a cycle restarts it
    do_reset(12, 5);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(cycle_pulse == 1'b0, "R7 pulse low in mid reset", cycle_pulse, 0);
    rst = 1'b0;
    first = 0;
    for (int i = 1; i <= 130; i++) begin
      @(negedge clk);
      if (cycle_pulse && first == 0) first = i;
    end
    check(first == 125, "R7 fresh cycle after mid reset", first, 125);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule